// File: doc/BRIEF.md
# Cell-Jitter Traffic Generator

This block stands in for a packet network in front of a clock-recovery receiver. It drains bytes from a transmit FIFO in fixed-size cells, one read pulse per byte. Between consecutive cells it waits for a random number of byte periods. The spacing is drawn from a statistical distribution that software chooses. One clock cycle of the block is one byte slot.

The random spacing is made in two steps. A shift-register sequence generator produces uniformly distributed addresses. It is extended to a full de Bruijn cycle, so it also visits the all-zero state. Each address selects a word from a loadable lookup table that holds the inverse of the cumulative distribution of the wanted spacing. That word loads a down-counter, which times the gap and then flags the start of the next cell. A level tracker counts FIFO write pulses against the block's own read pulses. When the tracked level is zero it raises a hold flag, and reads pause byte by byte until data arrives.

The table is written through a plain address/data/write-enable port while the generator is stopped. Typical use is to load a table whose mean approximates the wanted mean gap (for example about 164 byte periods between 47-byte cells), then raise the run input.

Top module: `jitter_cell_gen`

## Requirements
- R1: While reset is asserted and right after it, no read pulse and no cell-start pulse is issued, the generator is inactive, the tracked level is 0 and hold is 1.
- R2: The tracked level rises by one for a cycle with only a write pulse and falls by one for a cycle with only a read pulse. A cycle with both leaves it unchanged. It saturates at 2^LVL_W-1 (4095 by default).
- R3: Hold is 1 exactly when the tracked level is 0, and no read pulse is issued while hold is 1.
- R4: Every started cell issues exactly CELL_BYTES read pulses (47 by default). While hold is 1 the remaining reads are suspended one byte at a time, and none is dropped; they resume once data is present.
- R5: A gap value G is loaded when the generator starts and after the last read of each cell. The gap then lasts G+1 cycles with no read pulse. Cell-start is 1 in the last of those cycles, and the first read of the cell may occur in the following cycle.
- R6: Table lookups use the state of an LFSR_W-bit shift-register sequence. The sequence starts at LFSR_SEED (0x2D by default) after reset and advances once per gap load. Its period is 2^LFSR_W, so 2^LFSR_W consecutive gap loads use every table address exactly once. The first gap after reset is the table word at LFSR_SEED.
- R7: A write-enable while the generator is inactive stores tbl_data at tbl_addr. A write-enable while it is active is ignored and leaves the table unchanged.
- R8: With run high in the inactive state the generator starts a gap. When run goes low, a cell in progress still completes all its reads; the generator then returns to inactive without issuing cell-start, and active falls.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-slot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables cell generation |
| wr_pulse | input | 1 | One pulse per byte written into the FIFO |
| tbl_we | input | 1 | Distribution table write enable |
| tbl_addr | input | LFSR_W | Distribution table write address |
| tbl_data | input | GAP_W | Gap value to store |
| rd_pulse | output | 1 | One pulse per byte read from the FIFO |
| cell_start | output | 1 | Marks the slot before a cell's first read |
| hold | output | 1 | FIFO tracked as empty; reads suspended |
| active | output | 1 | Generator is not in its stopped state |
| fifo_level | output | LVL_W | Tracked FIFO occupancy |

## Verification
The assertions assume that wr_pulse counts real writes into the FIFO. They also assume the table is only rewritten while stopped, except for the deliberate writes issued during a run to prove they are ignored. The stimulus keeps write-enables inside the stopped window for every load it relies on. It pre-fills the tracked level far enough for a full sweep of all table addresses to run without hold. Hold is then provoked separately, after a fresh reset, with a sparse write stream.

// File: rtl/jit_pkg.sv
package jit_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_CELL = 2'd2
  } jit_state_e;
endpackage

// File: rtl/jit_lfsr.sv
// Shift-register address source, extended to a de Bruijn cycle (period 2^W).
module jit_lfsr #(
  parameter int          W    = 6,
  parameter logic [W-1:0] TAPS = 6'b110000,
  parameter logic [W-1:0] SEED = 6'h2D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] q, q_n;
  logic         fb;

  always_comb begin
    // the extra term inserts the all-zero state into the cycle
    fb  = (^(q & TAPS)) ^ (q[W-2:0] == '0);
    q_n = adv_i ? {q[W-2:0], fb} : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_n;
  end

  assign state_o = q;

  AST_LFSR_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(state_o)); // R6
endmodule

// File: rtl/jit_inv_table.sv
// Loadable inverse-distribution table, written only while stopped.
module jit_inv_table #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle_i,
  input  logic          we_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_ok;

  assign wr_ok = we_i && idle_i;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];

  AST_TBL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_i && $past(!idle_i) && $stable(rd_addr_i)) |-> $stable(rd_data_o)); // R7
endmodule

// File: rtl/jit_level_track.sv
// Occupancy tracker: writes minus reads, saturating.
module jit_level_track #(
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  output logic [LW-1:0] level_o,
  output logic          empty_o
);
  localparam logic [LW-1:0] LMAX = '1;

  logic [LW-1:0] lvl, lvl_n;

  always_comb begin
    lvl_n = lvl;
    if (wr_i && !rd_i && lvl != LMAX)      lvl_n = lvl + 1'b1;
    else if (!wr_i && rd_i && lvl != '0)   lvl_n = lvl - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else        lvl <= lvl_n;
  end

  assign level_o = lvl;
  assign empty_o = (lvl == '0);

  AST_LVL_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && rd_i) |=> $stable(level_o)); // R2
  AST_LVL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (level_o == LMAX && wr_i && !rd_i) |=> (level_o == LMAX)); // R2
endmodule

// File: rtl/jit_cell_ctrl.sv
// Gap timer and cell reader.
module jit_cell_ctrl
  import jit_pkg::*;
#(
  parameter int CELL_BYTES = 47,
  parameter int GW         = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          hold_i,
  input  logic [GW-1:0] gap_i,
  output logic          adv_o,
  output logic          rd_o,
  output logic          start_o,
  output logic          idle_o
);
  localparam int            BW   = (CELL_BYTES > 1) ? $clog2(CELL_BYTES) : 1;
  localparam logic [BW-1:0] LAST = BW'(CELL_BYTES - 1);

  jit_state_e    st, st_n;
  logic [GW-1:0] cnt, cnt_n;
  logic [BW-1:0] bcnt, bcnt_n;

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    bcnt_n = bcnt;
    adv_o  = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (run_i) begin
          st_n  = ST_GAP;
          cnt_n = gap_i;
          adv_o = 1'b1;
        end
      end
      ST_GAP: begin
        if (!run_i) begin
          st_n = ST_IDLE;
        end else if (cnt == '0) begin
          st_n   = ST_CELL;
          bcnt_n = '0;
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      ST_CELL: begin
        if (!hold_i) begin
          if (bcnt == LAST) begin
            st_n  = ST_GAP;
            cnt_n = gap_i;
            adv_o = 1'b1;
          end else begin
            bcnt_n = bcnt + 1'b1;
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      bcnt <= '0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      bcnt <= bcnt_n;
    end
  end

  assign rd_o    = (st == ST_CELL) && !hold_i;
  assign start_o = (st == ST_GAP) && (cnt == '0) && run_i;
  assign idle_o  = (st == ST_IDLE);

  AST_CELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CELL) |-> (bcnt <= LAST)); // R4
  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> (rd_o || hold_i)); // R5
endmodule

// File: rtl/jitter_cell_gen.sv
module jitter_cell_gen #(
  parameter int                CELL_BYTES = 47,
  parameter int                LFSR_W     = 6,
  parameter logic [LFSR_W-1:0] LFSR_TAPS  = 6'b110000,
  parameter logic [LFSR_W-1:0] LFSR_SEED  = 6'h2D,
  parameter int                GAP_W      = 9,
  parameter int                LVL_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_pulse,
  input  logic              tbl_we,
  input  logic [LFSR_W-1:0] tbl_addr,
  input  logic [GAP_W-1:0]  tbl_data,
  output logic              rd_pulse,
  output logic              cell_start,
  output logic              hold,
  output logic              active,
  output logic [LVL_W-1:0]  fifo_level
);
  logic [LFSR_W-1:0] addr;
  logic [GAP_W-1:0]  gap;
  logic              adv, idle, empty, rd;

  jit_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .adv_i(adv), .state_o(addr));

  jit_inv_table #(.AW(LFSR_W), .DW(GAP_W)) u_table (
    .clk(clk), .rst_n(rst_n), .idle_i(idle), .we_i(tbl_we),
    .wr_addr_i(tbl_addr), .wr_data_i(tbl_data),
    .rd_addr_i(addr), .rd_data_o(gap));

  jit_level_track #(.LW(LVL_W)) u_level (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_pulse), .rd_i(rd),
    .level_o(fifo_level), .empty_o(empty));

  jit_cell_ctrl #(.CELL_BYTES(CELL_BYTES), .GW(GAP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run), .hold_i(empty), .gap_i(gap),
    .adv_o(adv), .rd_o(rd), .start_o(cell_start), .idle_o(idle));

  assign rd_pulse = rd;
  assign hold     = empty;
  assign active   = !idle;

  AST_NO_READ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pulse |-> (fifo_level != '0)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!rd_pulse && !cell_start)); // R8
endmodule

// File: tb/jitter_cell_gen_bench.sv
`timescale 1ns/1ps
module jitter_cell_gen_bench;
  localparam int CELL = 47;
  localparam int AW   = 6;
  localparam int NADR = 1 << AW;
  localparam int GW   = 9;
  localparam int LW   = 12;
  localparam int LMAX = (1 << LW) - 1;
  localparam int SEED = 'h2D;

  logic clk = 1'b0;
  logic rst_n, run, wr_pulse, tbl_we;
  logic [AW-1:0] tbl_addr;
  logic [GW-1:0] tbl_data;
  logic rd_pulse, cell_start, hold, active;
  logic [LW-1:0] fifo_level;

  int n_chk = 0;
  int n_fail = 0;
  int ml = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jitter_cell_gen u_jitter_cell_gen (
    .clk(clk), .rst_n(rst_n), .run(run), .wr_pulse(wr_pulse),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .rd_pulse(rd_pulse), .cell_start(cell_start), .hold(hold),
    .active(active), .fifo_level(fifo_level));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock; level model follows the ports (R2, R3)
  task automatic step();
    logic w, r;
    w = wr_pulse;
    r = rd_pulse;
    if (r) chk(ml != 0, "R3 read while model level is zero", ml, 1);
    @(posedge clk);
    @(negedge clk);
    if (!rst_n) ml = 0;
    else if (w && !r && ml != LMAX) ml++;
    else if (!w && r && ml != 0) ml--;
    chk(int'(fifo_level) == ml, "R2 tracked level", int'(fifo_level), ml);
    chk(hold == (ml == 0), "R3 hold flag", int'(hold), int'(ml == 0));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run = 1'b0; wr_pulse = 1'b0; tbl_we = 1'b0;
    tbl_addr = '0; tbl_data = '0;
    repeat (3) step();
    chk(!rd_pulse && !cell_start && !active, "R1 quiet in reset",
        int'({rd_pulse, cell_start, active}), 0);
    rst_n = 1'b1;
    step();
    chk(!rd_pulse && !cell_start && !active && hold && fifo_level == '0,
        "R1 state after reset", int'({rd_pulse, cell_start, active, hold}), 1);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit seen [NADR];
    int idle_n, rc, ncell, g, starts, nseen, reads;
    bit prev_start;
    @(negedge clk);
    do_reset();

    // R7: table load while stopped, word at address a is a
    for (int a = 0; a < NADR; a++) begin
      tbl_we = 1'b1; tbl_addr = AW'(a); tbl_data = GW'(a);
      step();
    end
    tbl_we = 1'b0;

    // R2: saturation of the tracked level
    wr_pulse = 1'b1;
    repeat (LMAX + 8) step();
    wr_pulse = 1'b0;
    chk(int'(fifo_level) == LMAX, "R2 saturation", int'(fifo_level), LMAX);

    // R5 R6 R4 R7: sweep of all gap loads, with ignored writes while running
    for (int a = 0; a < NADR; a++) seen[a] = 1'b0;
    idle_n = 0; rc = 0; ncell = 0; prev_start = 1'b0;
    run = 1'b1;
    for (int k = 0; k < 20000 && ncell < NADR; k++) begin
      step();
      if (rd_pulse) begin
        if (idle_n > 0) begin
          if (ncell > 0) chk(rc == CELL, "R4 reads per cell", rc, CELL);
          chk(prev_start, "R5 cell_start precedes first read", int'(prev_start), 1);
          g = idle_n - 1;
          chk(g >= 0 && g < NADR && !seen[g], "R6 gap address used once", g, -1);
          if (g >= 0 && g < NADR) seen[g] = 1'b1;
          if (ncell == 0) chk(g == SEED, "R6 first gap from seed", g, SEED);
          ncell++;
          rc = 0;
          idle_n = 0;
        end
        rc++;
      end else begin
        idle_n++;
      end
      prev_start = cell_start;
      // R7: writes issued while active must be ignored
      tbl_we   = (k < NADR) && active;
      tbl_addr = AW'(k);
      tbl_data = '0;
    end
    tbl_we = 1'b0;
    nseen = 0;
    for (int a = 0; a < NADR; a++) nseen += int'(seen[a]);
    chk(nseen == NADR, "R6 full period of addresses", nseen, NADR);

    // R8: drop run inside a cell, the cell still completes
    run = 1'b0;
    starts = 0;
    for (int k = 0; k < 200 && active; k++) begin
      step();
      if (rd_pulse) rc++;
      if (cell_start) starts++;
    end
    chk(rc == CELL, "R8 cell completes after run low", rc, CELL);
    chk(starts == 0, "R8 no cell_start after run low", starts, 0);
    chk(!active, "R8 active falls", int'(active), 0);

    // R3 R4: hold behaviour after a fresh reset, all gaps = 2
    do_reset();
    for (int a = 0; a < NADR; a++) begin
      tbl_we = 1'b1; tbl_addr = AW'(a); tbl_data = GW'(2);
      step();
    end
    tbl_we = 1'b0;
    wr_pulse = 1'b1;
    repeat (10) step();
    wr_pulse = 1'b0;
    run = 1'b1;
    idle_n = 0;
    for (int k = 0; k < 20; k++) begin
      step();
      if (rd_pulse) break;
      idle_n++;
    end
    chk(idle_n == 3, "R5 first gap of G=2 lasts three slots", idle_n, 3);
    reads = 1;
    repeat (60) begin
      step();
      reads += int'(rd_pulse);
    end
    chk(reads == 10, "R4 reads stop at empty", reads, 10);
    chk(hold && active, "R3 hold mid-cell", int'({hold, active}), 3);
    starts = 0;
    for (int i = 0; i < 130; i++) begin
      wr_pulse = (i % 3 == 0) && (i < 111);
      step();
      reads += int'(rd_pulse);
      starts += int'(cell_start);
    end
    wr_pulse = 1'b0;
    chk(reads == CELL, "R4 no read dropped under hold", reads, CELL);
    chk(starts == 1, "R5 next cell started after gap", starts, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule